// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Deferred Backlog

This block decides when a DRAM controller owes the memory a refresh and how hard it should push for one. A programmable down-counter marks each refresh obligation: every expiry adds one owed refresh to a backlog counter. The command arbiter removes one owed refresh each time it accepts a refresh command. A refresh is requested only while the command bus is idle, so read and write traffic is not disturbed, until the backlog gets large enough that the block demands service no matter what traffic is pending.

The backlog is mapped to a two-bit urgency level. At the top level the request is forced. The forced state has hysteresis: it starts when seven refreshes are owed and lasts until only two remain, so a burst of refreshes goes out back to back. At 8 owed refreshes the counter stops counting and a sticky flag records the overflow. For example, an interval value of 3120 at a 400 MHz clock gives one obligation every 7.8 us.

Top module: `refresh_sched`

## Requirements
- R1: After reset the backlog count is 0, urgency is 0, the request is low and the overflow flag is low.
- R2: With a non-zero interval value N, the counter loads N on the first clock after reset or after being enabled, and then expires once every N cycles. The first expiry therefore falls on the (N+1)-th rising edge after enabling.
- R3: Each expiry without an accept in the same cycle raises the backlog by one. The backlog saturates at 8. The overflow flag rises in the same cycle the backlog reaches 8 and stays high until reset.
- R4: An accept pulse lowers a non-zero backlog by one. An accept while the backlog is 0 has no effect.
- R5: When an expiry and an accept fall in the same cycle, the backlog is left unchanged.
- R6: Urgency encoding: 0 when the backlog is 0; 1 for backlog 1 to 3; 2 for backlog 4 to 6; 3 while in the forced state.
- R7: The forced state begins when the backlog reaches 7. It is held as the backlog falls and is left only when the backlog drops to 2 or below.
- R8: The request is high while the interval value is non-zero and either the forced state holds, or the backlog is non-zero and the bus is idle. The request drops in the cycle after an accept that empties the backlog or that ends the forced state (with a busy bus).
- R9: An interval value of 0 stops expiries, holds the request low and keeps the backlog where it is.
- R10: A new interval value written mid-count does not shorten or stretch the current interval. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intervalCfg | input | 16 | Cycles between refresh obligations; 0 disables |
| busIdle | input | 1 | High when no read or write traffic is waiting |
| refreshAck | input | 1 | One-cycle pulse: the arbiter issued a refresh |
| refreshReq | output | 1 | Refresh wanted by the scheduler |
| urgency | output | 2 | 0 none, 1 opportunistic, 2 high, 3 forced |
| backlogCount | output | 4 | Number of refreshes currently owed |
| overflowErr | output | 1 | Sticky: the backlog has reached 8 |

## Verification
The assertions check on every cycle the relations that hold between the outputs at any moment. The backlog never exceeds 8, and the overflow flag stays set and is set whenever the backlog is full. A backlog of 0 means calm urgency and no request. A backlog of 7 or more means urgency 3. The forced state always raises the request when enabled, and a disabled interval never requests. The timing behaviours can only be shown by the bench's scenarios: when the first expiry lands, how a mid-count interval change is deferred, the exact cycle in which an expiry collides with an accept, and the hysteresis path down from 8 through 3. The bench's reference model, compared every clock, covers these.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    URG_NONE      = 2'd0,
    URG_OPPORTUNE = 2'd1,
    URG_HIGH      = 2'd2,
    URG_MUST      = 2'd3
  } urgency_e;

  // Strobes from control to datapath; never both high.
  typedef struct packed {
    logic bump;   // add one owed refresh
    logic drain;  // remove one owed refresh
  } blStrobe_t;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int INTERVAL_W  = 16,
  parameter int BACKLOG_MAX = 8,
  parameter int BL_W        = $clog2(BACKLOG_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INTERVAL_W-1:0] intervalCfg,
  input  blStrobe_t             strobe,
  output logic                  enabled,
  output logic                  intervalTick,
  output logic [BL_W-1:0]       backlogQ,
  output logic [BL_W-1:0]       backlogD,
  output logic                  overflowErr
);

  localparam logic [BL_W-1:0]       MAX_V = BL_W'(BACKLOG_MAX);
  localparam logic [INTERVAL_W-1:0] ONE_I = INTERVAL_W'(1);

  logic [INTERVAL_W-1:0] countQ;
  logic                  errQ;

  assign enabled      = |intervalCfg;
  assign intervalTick = enabled && (countQ == ONE_I);

  // Down-counter: 0 means unloaded, 1 means expiring this cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (!enabled) begin
      countQ <= '0;
    end else if (countQ <= ONE_I) begin
      countQ <= intervalCfg;
    end else begin
      countQ <= countQ - ONE_I;
    end
  end

  always_comb begin
    backlogD = backlogQ;
    if (strobe.bump) begin
      if (backlogQ != MAX_V) backlogD = backlogQ + 1'b1;
    end else if (strobe.drain) begin
      backlogD = backlogQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      backlogQ <= '0;
      errQ     <= 1'b0;
    end else begin
      backlogQ <= backlogD;
      errQ     <= errQ | (backlogD == MAX_V);
    end
  end

  assign overflowErr = errQ;

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int BACKLOG_MAX   = 8,
  parameter int HIGH_LEVEL    = 4,
  parameter int MUST_LEVEL    = 7,
  parameter int RELEASE_LEVEL = 2,
  parameter int BL_W          = $clog2(BACKLOG_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enabled,
  input  logic            intervalTick,
  input  logic            busIdle,
  input  logic            refreshAck,
  input  logic [BL_W-1:0] backlogQ,
  input  logic [BL_W-1:0] backlogD,
  output blStrobe_t       strobe,
  output urgency_e        urgState,
  output logic            refreshReq
);

  localparam logic [BL_W-1:0] HIGH_V = BL_W'(HIGH_LEVEL);
  localparam logic [BL_W-1:0] MUST_V = BL_W'(MUST_LEVEL);
  localparam logic [BL_W-1:0] REL_V  = BL_W'(RELEASE_LEVEL);

  logic mustQ;
  logic mustD;
  logic owed;

  assign owed = (backlogQ != '0);

  // An expiry and an accept in one cycle cancel each other.
  always_comb begin
    strobe.bump  = intervalTick & ~refreshAck;
    strobe.drain = refreshAck & ~intervalTick & owed;
  end

  // Forced state with hysteresis, tracked against the next backlog.
  always_comb begin
    if (backlogD >= MUST_V)      mustD = 1'b1;
    else if (backlogD <= REL_V)  mustD = 1'b0;
    else                         mustD = mustQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mustQ <= 1'b0;
    else        mustQ <= mustD;
  end

  always_comb begin
    if (mustQ)                   urgState = URG_MUST;
    else if (backlogQ >= HIGH_V) urgState = URG_HIGH;
    else if (owed)               urgState = URG_OPPORTUNE;
    else                         urgState = URG_NONE;
  end

  assign refreshReq = enabled && (mustQ || (owed && busIdle));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int INTERVAL_W    = 16,
  parameter int BACKLOG_MAX   = 8,
  parameter int HIGH_LEVEL    = 4,
  parameter int MUST_LEVEL    = 7,
  parameter int RELEASE_LEVEL = 2,
  localparam int BL_W         = $clog2(BACKLOG_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INTERVAL_W-1:0] intervalCfg,
  input  logic                  busIdle,
  input  logic                  refreshAck,
  output logic                  refreshReq,
  output logic [1:0]            urgency,
  output logic [BL_W-1:0]       backlogCount,
  output logic                  overflowErr
);

  blStrobe_t       strobe;
  urgency_e        urgState;
  logic            enabled;
  logic            intervalTick;
  logic [BL_W-1:0] backlogQ;
  logic [BL_W-1:0] backlogD;

  refresh_dp #(
    .INTERVAL_W (INTERVAL_W),
    .BACKLOG_MAX(BACKLOG_MAX),
    .BL_W       (BL_W)
  ) uDp (
    .clk         (clk),
    .rst_n       (rst_n),
    .intervalCfg (intervalCfg),
    .strobe      (strobe),
    .enabled     (enabled),
    .intervalTick(intervalTick),
    .backlogQ    (backlogQ),
    .backlogD    (backlogD),
    .overflowErr (overflowErr)
  );

  refresh_ctrl #(
    .BACKLOG_MAX  (BACKLOG_MAX),
    .HIGH_LEVEL   (HIGH_LEVEL),
    .MUST_LEVEL   (MUST_LEVEL),
    .RELEASE_LEVEL(RELEASE_LEVEL),
    .BL_W         (BL_W)
  ) uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enabled     (enabled),
    .intervalTick(intervalTick),
    .busIdle     (busIdle),
    .refreshAck  (refreshAck),
    .backlogQ    (backlogQ),
    .backlogD    (backlogD),
    .strobe      (strobe),
    .urgState    (urgState),
    .refreshReq  (refreshReq)
  );

  assign urgency      = urgState;
  assign backlogCount = backlogQ;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int INTERVAL_W    = 16,
  parameter int BACKLOG_MAX   = 8,
  parameter int MUST_LEVEL    = 7,
  parameter int RELEASE_LEVEL = 2,
  parameter int BL_W          = $clog2(BACKLOG_MAX + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [INTERVAL_W-1:0] intervalCfg,
  input logic                  refreshAck,
  input logic                  refreshReq,
  input logic [1:0]            urgency,
  input logic [BL_W-1:0]       backlogCount,
  input logic                  overflowErr
);

  localparam logic [BL_W-1:0] MAX_V  = BL_W'(BACKLOG_MAX);
  localparam logic [BL_W-1:0] MUST_V = BL_W'(MUST_LEVEL);
  localparam logic [BL_W-1:0] REL_V  = BL_W'(RELEASE_LEVEL);

  assert_backlog_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    backlogCount <= MAX_V);

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |=> overflowErr);

  assert_err_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (backlogCount == MAX_V) |-> overflowErr);

  assert_ack_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refreshAck && backlogCount != '0) |=> (backlogCount <= $past(backlogCount)));

  assert_empty_calm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (backlogCount == '0) |-> (urgency == 2'd0));

  assert_must_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (backlogCount >= MUST_V) |-> (urgency == 2'd3));

  assert_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (backlogCount <= REL_V) |-> (urgency != 2'd3));

  assert_must_requests_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (urgency == 2'd3 && intervalCfg != '0) |-> refreshReq);

  assert_empty_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (backlogCount == '0) |-> !refreshReq);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (intervalCfg == '0) |-> !refreshReq);

endmodule

bind refresh_sched refresh_sched_chk #(
  .INTERVAL_W   (INTERVAL_W),
  .BACKLOG_MAX  (BACKLOG_MAX),
  .MUST_LEVEL   (MUST_LEVEL),
  .RELEASE_LEVEL(RELEASE_LEVEL),
  .BL_W         (BL_W)
) uChk (
  .clk         (clk),
  .rst_n       (rst_n),
  .intervalCfg (intervalCfg),
  .refreshAck  (refreshAck),
  .refreshReq  (refreshReq),
  .urgency     (urgency),
  .backlogCount(backlogCount),
  .overflowErr (overflowErr)
);

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;

  localparam int CLK_PERIOD = 10;
  localparam int BMAX       = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] intervalCfg = '0;
  logic        busIdle = 1'b0;
  logic        refreshAck = 1'b0;
  logic        refreshReq;
  logic [1:0]  urgency;
  logic [3:0]  backlogCount;
  logic        overflowErr;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  int mLeft  = 0;
  bit mArmed = 0;
  int mBl    = 0;
  bit mMust  = 0;
  bit mErr   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .intervalCfg (intervalCfg),
    .busIdle     (busIdle),
    .refreshAck  (refreshAck),
    .refreshReq  (refreshReq),
    .urgency     (urgency),
    .backlogCount(backlogCount),
    .overflowErr (overflowErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expUrgency(int bl, bit must);
    if (must)       return 3;
    else if (bl >= 4) return 2;
    else if (bl >= 1) return 1;
    return 0;
  endfunction

  // Model advances on each edge, then compares a little later.
  always @(posedge clk) begin
    bit tick;
    int expReq;
    tick = 0;
    if (!rst_n) begin
      mArmed = 0; mLeft = 0; mBl = 0; mMust = 0; mErr = 0;
    end else begin
      if (intervalCfg == 0) mArmed = 0;
      else if (!mArmed) begin mArmed = 1; mLeft = intervalCfg; end
      else if (mLeft == 1) begin tick = 1; mLeft = intervalCfg; end
      else mLeft = mLeft - 1;

      if (tick && refreshAck) begin end
      else if (tick) begin if (mBl < BMAX) mBl = mBl + 1; end
      else if (refreshAck && mBl > 0) mBl = mBl - 1;

      if (mBl == BMAX) mErr = 1;
      if (mBl >= 7) mMust = 1;
      else if (mBl <= 2) mMust = 0;
    end
    #3;
    if (rst_n) begin
      expReq = (intervalCfg != 0) && (mMust || (mBl != 0 && busIdle));
      check(backlogCount == mBl, "R3 model backlog", backlogCount, mBl);
      check(urgency == expUrgency(mBl, mMust), "R6 model urgency", urgency, expUrgency(mBl, mMust));
      check(refreshReq == expReq, "R8 model request", refreshReq, expReq);
      check(overflowErr == mErr, "R3 model overflow", overflowErr, mErr);
    end
  end

  task automatic pulseAck();
    refreshAck = 1'b1;
    @(negedge clk);
    refreshAck = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int v;
    int cnt;
    int lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(backlogCount == 0, "R1 backlog", backlogCount, 0);
    check(urgency == 0, "R1 urgency", urgency, 0);
    check(refreshReq == 0, "R1 request", refreshReq, 0);
    check(overflowErr == 0, "R1 overflow", overflowErr, 0);

    // R2: first expiry on the 6th edge with N=5, bus busy
    intervalCfg = 16'd5;
    busIdle = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(backlogCount == 0, "R2 before expiry", backlogCount, 0);
    @(negedge clk);
    check(backlogCount == 1, "R2 first expiry", backlogCount, 1);
    check(urgency == 1, "R6 opportunistic", urgency, 1);
    check(refreshReq == 0, "R8 busy holds off", refreshReq, 0);

    // R7: forced at 7 even with a busy bus
    cnt = 0;
    while (backlogCount != 7 && cnt < 200) begin @(negedge clk); cnt++; end
    check(urgency == 3, "R7 forced at 7", urgency, 3);
    check(refreshReq == 1, "R8 forced request", refreshReq, 1);

    // R3: saturation and sticky overflow
    cnt = 0;
    while (backlogCount != 8 && cnt < 200) begin @(negedge clk); cnt++; end
    check(overflowErr == 1, "R3 overflow raised", overflowErr, 1);
    repeat (12) @(negedge clk);
    check(backlogCount == 8, "R3 saturated", backlogCount, 8);

    // R7: hysteresis on the way down
    cnt = 0;
    while (backlogCount > 3 && cnt < 100) begin pulseAck(); cnt++; end
    check(urgency == 3, "R7 still forced at 3", urgency, 3);
    cnt = 0;
    while (backlogCount > 2 && cnt < 100) begin pulseAck(); cnt++; end
    check(urgency == 1, "R7 released at 2", urgency, 1);
    check(refreshReq == 0, "R8 drop after release", refreshReq, 0);
    check(overflowErr == 1, "R3 overflow sticky", overflowErr, 1);

    // R5: accept landing on an expiry edge
    v = backlogCount;
    cnt = 0;
    while (backlogCount == v && cnt < 20) begin @(negedge clk); cnt++; end
    v = backlogCount;
    repeat (4) @(negedge clk);
    pulseAck();
    check(backlogCount == v, "R5 expiry with accept", backlogCount, v);

    // R10: new interval after the pending reload
    intervalCfg = 16'd12;
    repeat (4) @(negedge clk);
    check(backlogCount == v, "R10 old interval running", backlogCount, v);
    @(negedge clk);
    check(backlogCount == v + 1, "R10 old interval expiry", backlogCount, v + 1);
    repeat (11) @(negedge clk);
    check(backlogCount == v + 1, "R10 new interval running", backlogCount, v + 1);
    @(negedge clk);
    check(backlogCount == v + 2, "R10 new interval expiry", backlogCount, v + 2);

    // R8 / R9: idle request, then disable
    v = backlogCount;
    busIdle = 1'b1;
    @(negedge clk);
    check(refreshReq == 1, "R8 idle request", refreshReq, 1);
    intervalCfg = 16'd0;
    @(negedge clk);
    check(refreshReq == 0, "R9 disabled request", refreshReq, 0);
    repeat (30) @(negedge clk);
    check(backlogCount == v, "R9 backlog frozen", backlogCount, v);

    // R4: accepts drain one at a time, accept at zero ignored
    for (int i = v; i > 0; i--) begin
      pulseAck();
      check(backlogCount == i - 1, "R4 drain step", backlogCount, i - 1);
    end
    pulseAck();
    check(backlogCount == 0, "R4 accept at zero", backlogCount, 0);
    check(urgency == 0, "R6 empty urgency", urgency, 0);

    // Mixed traffic against the model
    intervalCfg = 16'd3;
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      busIdle = lfsr[3];
      refreshAck = lfsr[5] & lfsr[7];
      if (i == 200) intervalCfg = 16'd1;
      if (i == 300) intervalCfg = 16'd7;
      @(negedge clk);
    end
    refreshAck = 1'b0;
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule